// File: doc/BRIEF.md
# Counter Access-Control Register Trap Arbiter

This block judges a system-register read or write that targets the register controlling lower-privilege access to the performance counters. When a request arrives with a matching encoding, the block looks at the requester's exception level and at the trap and enable controls owned by levels 2 and 3. It then walks a fixed priority chain and reports exactly one outcome: the access is permitted, the instruction is undefined, the access traps to level 2, or the access traps to level 3. A trapped access also carries its 6-bit exception class.

The chain depends on the requesting level. Level 0 is always refused and level 3 is always allowed. Level 1 sees every check. Level 2 skips the checks that level 2 itself owns. An undefined-priority mode lifts two level-3 checks to the head of the chain and turns them into undefined outcomes. Reads and writes go through the same logic. The only difference is which fine-grained allow bit is consulted. The verdict is registered and appears one cycle after the request.

Top module: `ctr_acc_trap_arb`

## Requirements
- R1: A request is recognised only when its encoding fields are op0=2'b11, op1=3'b000, CRn=4'b1001, CRm=4'b1110 and op2=3'b100. Any other request, or a cycle with no request, gives `rsp_valid_o`=0 with `rsp_result_o`=0 and `rsp_ec_o`=0 on the next cycle.
- R2: A recognised request raises `rsp_valid_o` exactly one clock later. The result codes are 2'b00 permit, 2'b01 undefined, 2'b10 trap to level 2 and 2'b11 trap to level 3.
- R3: A recognised request from level 0 (`cur_el_i`=0) gives undefined, whatever the control inputs are.
- R4: At levels 1 and 2, when level 3 exists and `undef_prio_i`=1, either `l3_ctr_en_i`=0 or `l3_trap_i`=1 gives undefined. This check takes precedence over every other check.
- R5: At level 1, when level 2 is present and enabled and `fgt_present_i`=1, the access traps to level 2 in either of two cases. The first is that level 3 exists with `l3_fgt_en_i`=0. The second is that the allow bit for the access direction is 0 (`l2_rd_allow_i` for a read, `l2_wr_allow_i` for a write).
- R6: At level 1, if R5 does not fire, a present and enabled level 2 with `l2_trap_i`=1 gives a trap to level 2.
- R7: At levels 1 and 2, once the earlier checks pass, a present level 3 with `l3_ctr_en_i`=0 or `l3_trap_i`=1 gives a trap to level 3. If `undef_sel_i`=1, the outcome is undefined instead.
- R8: At level 2 the level-2 checks of R5 and R6 never apply, so the result is never a trap to level 2.
- R9: A recognised request from level 3 is always permitted.
- R10: `rsp_ec_o` is 6'h18 when a valid result is a trap to level 2 or level 3, and 0 otherwise.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| enc_op0_i | input | 2 | Encoding field op0 |
| enc_op1_i | input | 3 | Encoding field op1 |
| enc_crn_i | input | 4 | Encoding field CRn |
| enc_crm_i | input | 4 | Encoding field CRm |
| enc_op2_i | input | 3 | Encoding field op2 |
| cur_el_i | input | 2 | Exception level of the requester |
| has_el2_i | input | 1 | Level 2 is implemented |
| has_el3_i | input | 1 | Level 3 is implemented |
| el2_enabled_i | input | 1 | Level 2 is enabled in the current state |
| l3_ctr_en_i | input | 1 | Level-3 counter-access enable |
| l3_trap_i | input | 1 | Level-3 counter trap bit |
| l2_trap_i | input | 1 | Level-2 counter trap bit |
| fgt_present_i | input | 1 | Fine-grained trap feature implemented |
| l3_fgt_en_i | input | 1 | Level-3 enable for fine-grained traps |
| l2_rd_allow_i | input | 1 | Level-2 fine-grained read allow bit |
| l2_wr_allow_i | input | 1 | Level-2 fine-grained write allow bit |
| undef_prio_i | input | 1 | Undefined-priority mode |
| undef_sel_i | input | 1 | Level-3 conditions give undefined instead of a trap |
| rsp_valid_o | output | 1 | Verdict strobe |
| rsp_result_o | output | 2 | Verdict code |
| rsp_ec_o | output | 6 | Exception class of a trap |

## Verification
The assertions treat the control inputs as stable levels sampled together with `req_valid_i`. They assume a level-2 request only arrives when `has_el2_i` is 1, and that `el2_enabled_i` is only set when level 2 is present. The stimulus keeps to these assumptions: every random vector that picks level 2 or sets the enable also forces the presence flag. Directed vectors hold the other controls permissive while they flip the one condition under test, so each link of the chain is isolated.

// File: rtl/ctr_acc_pkg.sv
package ctr_acc_pkg;

   typedef enum logic [1:0] {
      ACC_PERMIT  = 2'b00,
      ACC_UNDEF   = 2'b01,
      ACC_TRAP_L2 = 2'b10,
      ACC_TRAP_L3 = 2'b11
   } acc_res_e;

   typedef struct packed {
      logic has_el2;
      logic has_el3;
      logic el2_enabled;
      logic l3_ctr_en;
      logic l3_trap;
      logic l2_trap;
      logic fgt_present;
      logic l3_fgt_en;
      logic l2_rd_allow;
      logic l2_wr_allow;
      logic undef_prio;
      logic undef_sel;
   } ctl_t;

   typedef struct packed {
      logic at_el0;
      logic early_undef;
      logic fgt_l2;
      logic tpm_l2;
      logic route_l3;
      logic l3_as_undef;
   } cond_t;

endpackage

// File: rtl/cat_enc_match.sv
module cat_enc_match #(
   parameter int          OP0_W = 2,
   parameter int          OP1_W = 3,
   parameter int          CRN_W = 4,
   parameter int          CRM_W = 4,
   parameter int          OP2_W = 3,
   parameter logic [OP0_W-1:0] OP0_V = 2'b11,
   parameter logic [OP1_W-1:0] OP1_V = 3'b000,
   parameter logic [CRN_W-1:0] CRN_V = 4'b1001,
   parameter logic [CRM_W-1:0] CRM_V = 4'b1110,
   parameter logic [OP2_W-1:0] OP2_V = 3'b100
) (
   input  logic [OP0_W-1:0] op0_i,
   input  logic [OP1_W-1:0] op1_i,
   input  logic [CRN_W-1:0] crn_i,
   input  logic [CRM_W-1:0] crm_i,
   input  logic [OP2_W-1:0] op2_i,
   output logic             hit_o
);
   localparam int NFLD = 5;
   logic [NFLD-1:0] fld_eq;

   always_comb begin
      fld_eq[0] = (op0_i == OP0_V);
      fld_eq[1] = (op1_i == OP1_V);
      fld_eq[2] = (crn_i == CRN_V);
      fld_eq[3] = (crm_i == CRM_V);
      fld_eq[4] = (op2_i == OP2_V);
   end

   assign hit_o = &fld_eq;
endmodule

// File: rtl/cat_cond_eval.sv
module cat_cond_eval
   import ctr_acc_pkg::*;
#(
   parameter int EL_W     = 2,
   parameter bit FGT_IMPL = 1'b1
) (
   input  logic [EL_W-1:0] el_i,
   input  logic            write_i,
   input  ctl_t            ctl_i,
   output cond_t           cond_o
);
   logic at_el1, at_el2, at_el12;
   logic el2_live, l3_block, dir_allow, fgt_hit;

   always_comb begin
      at_el1    = (el_i == EL_W'(1));
      at_el2    = (el_i == EL_W'(2));
      at_el12   = at_el1 | at_el2;
      el2_live  = ctl_i.has_el2 & ctl_i.el2_enabled;
      l3_block  = ctl_i.has_el3 & (~ctl_i.l3_ctr_en | ctl_i.l3_trap);
      dir_allow = write_i ? ctl_i.l2_wr_allow : ctl_i.l2_rd_allow;
   end

   generate
      if (FGT_IMPL) begin : g_fgt
         assign fgt_hit = ctl_i.fgt_present &
                          ((ctl_i.has_el3 & ~ctl_i.l3_fgt_en) | ~dir_allow);
      end else begin : g_no_fgt
         logic unused_fgt;
         assign unused_fgt = ^{dir_allow, ctl_i.fgt_present, ctl_i.l3_fgt_en};
         assign fgt_hit    = 1'b0;
      end
   endgenerate

   always_comb begin
      cond_o.at_el0      = (el_i == '0);
      cond_o.early_undef = at_el12 & ctl_i.undef_prio & l3_block;
      cond_o.fgt_l2      = at_el1 & el2_live & fgt_hit;
      cond_o.tpm_l2      = at_el1 & el2_live & ctl_i.l2_trap;
      cond_o.route_l3    = at_el12 & l3_block;
      cond_o.l3_as_undef = ctl_i.undef_sel;
   end
endmodule

// File: rtl/cat_prio_sel.sv
module cat_prio_sel
   import ctr_acc_pkg::*;
#(
   parameter int          EC_W    = 6,
   parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
   input  cond_t           cond_i,
   output acc_res_e        res_o,
   output logic [EC_W-1:0] ec_o
);
   always_comb begin
      if (cond_i.at_el0)            res_o = ACC_UNDEF;
      else if (cond_i.early_undef)  res_o = ACC_UNDEF;
      else if (cond_i.fgt_l2)       res_o = ACC_TRAP_L2;
      else if (cond_i.tpm_l2)       res_o = ACC_TRAP_L2;
      else if (cond_i.route_l3)     res_o = cond_i.l3_as_undef ? ACC_UNDEF : ACC_TRAP_L3;
      else                          res_o = ACC_PERMIT;
      ec_o = res_o[1] ? TRAP_EC : '0;
   end
endmodule

// File: rtl/ctr_acc_trap_arb.sv
module ctr_acc_trap_arb
   import ctr_acc_pkg::*;
#(
   parameter int          EL_W     = 2,
   parameter int          EC_W     = 6,
   parameter logic [EC_W-1:0] TRAP_EC = 6'h18,
   parameter bit          FGT_IMPL = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            req_valid_i,
   input  logic            req_write_i,
   input  logic [1:0]      enc_op0_i,
   input  logic [2:0]      enc_op1_i,
   input  logic [3:0]      enc_crn_i,
   input  logic [3:0]      enc_crm_i,
   input  logic [2:0]      enc_op2_i,
   input  logic [EL_W-1:0] cur_el_i,
   input  logic            has_el2_i,
   input  logic            has_el3_i,
   input  logic            el2_enabled_i,
   input  logic            l3_ctr_en_i,
   input  logic            l3_trap_i,
   input  logic            l2_trap_i,
   input  logic            fgt_present_i,
   input  logic            l3_fgt_en_i,
   input  logic            l2_rd_allow_i,
   input  logic            l2_wr_allow_i,
   input  logic            undef_prio_i,
   input  logic            undef_sel_i,
   output logic            rsp_valid_o,
   output logic [1:0]      rsp_result_o,
   output logic [EC_W-1:0] rsp_ec_o
);
   localparam int EC_MAX = (1 << EC_W) - 1;

   generate
      if (EL_W != 2) begin : g_bad_el
         $error("EL_W must be 2");
      end
      if (EC_W < 1 || EC_W > 16) begin : g_bad_ec
         $error("EC_W out of range");
      end
      if (int'(TRAP_EC) == 0 || int'(TRAP_EC) > EC_MAX) begin : g_bad_trap_ec
         $error("TRAP_EC must be nonzero and fit EC_W");
      end
   endgenerate

   ctl_t            ctl;
   cond_t           cond;
   acc_res_e        res_d;
   logic [EC_W-1:0] ec_d;
   logic            enc_hit;

   always_comb begin
      ctl.has_el2     = has_el2_i;
      ctl.has_el3     = has_el3_i;
      ctl.el2_enabled = el2_enabled_i;
      ctl.l3_ctr_en   = l3_ctr_en_i;
      ctl.l3_trap     = l3_trap_i;
      ctl.l2_trap     = l2_trap_i;
      ctl.fgt_present = fgt_present_i;
      ctl.l3_fgt_en   = l3_fgt_en_i;
      ctl.l2_rd_allow = l2_rd_allow_i;
      ctl.l2_wr_allow = l2_wr_allow_i;
      ctl.undef_prio  = undef_prio_i;
      ctl.undef_sel   = undef_sel_i;
   end

   cat_enc_match i_match (
      .op0_i (enc_op0_i),
      .op1_i (enc_op1_i),
      .crn_i (enc_crn_i),
      .crm_i (enc_crm_i),
      .op2_i (enc_op2_i),
      .hit_o (enc_hit)
   );

   cat_cond_eval #(.EL_W(EL_W), .FGT_IMPL(FGT_IMPL)) i_cond (
      .el_i    (cur_el_i),
      .write_i (req_write_i),
      .ctl_i   (ctl),
      .cond_o  (cond)
   );

   cat_prio_sel #(.EC_W(EC_W), .TRAP_EC(TRAP_EC)) i_prio (
      .cond_i (cond),
      .res_o  (res_d),
      .ec_o   (ec_d)
   );

   logic accept;
   assign accept = req_valid_i & enc_hit;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rsp_valid_o  <= 1'b0;
         rsp_result_o <= '0;
         rsp_ec_o     <= '0;
      end else begin
         rsp_valid_o  <= accept;
         rsp_result_o <= accept ? res_d : ACC_PERMIT;
         rsp_ec_o     <= accept ? ec_d : '0;
      end
   end
endmodule

// File: rtl/ctr_acc_trap_chk.sv
module ctr_acc_trap_chk #(
   parameter int EC_W = 6,
   parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            req_valid_i,
   input logic [1:0]      enc_op0_i,
   input logic [2:0]      enc_op1_i,
   input logic [3:0]      enc_crn_i,
   input logic [3:0]      enc_crm_i,
   input logic [2:0]      enc_op2_i,
   input logic [1:0]      cur_el_i,
   input logic            has_el3_i,
   input logic            l3_ctr_en_i,
   input logic            l3_trap_i,
   input logic            undef_prio_i,
   input logic            rsp_valid_o,
   input logic [1:0]      rsp_result_o,
   input logic [EC_W-1:0] rsp_ec_o
);
   logic enc_ok;
   assign enc_ok = (enc_op0_i == 2'b11) && (enc_op1_i == 3'b000) &&
                   (enc_crn_i == 4'b1001) && (enc_crm_i == 4'b1110) &&
                   (enc_op2_i == 3'b100);

   p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && enc_ok) |=> rsp_valid_o);

   p_reject_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_valid_i && enc_ok) |=> (!rsp_valid_o && rsp_result_o == 2'b00 && rsp_ec_o == '0));

   p_el0_undef_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && enc_ok && cur_el_i == 2'd0) |=> (rsp_result_o == 2'b01));

   p_early_undef_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && enc_ok && (cur_el_i == 2'd1 || cur_el_i == 2'd2) && has_el3_i &&
       undef_prio_i && (!l3_ctr_en_i || l3_trap_i)) |=> (rsp_result_o == 2'b01));

   p_el2_no_l2trap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && enc_ok && cur_el_i == 2'd2) |=> (rsp_result_o != 2'b10));

   p_el3_permit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && enc_ok && cur_el_i == 2'd3) |=> (rsp_result_o == 2'b00));

   p_trap_ec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && rsp_result_o[1]) |-> (rsp_ec_o == TRAP_EC));

   p_notrap_ec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rsp_valid_o && rsp_result_o[1]) |-> (rsp_ec_o == '0));
endmodule

bind ctr_acc_trap_arb ctr_acc_trap_chk #(.EC_W(EC_W), .TRAP_EC(TRAP_EC)) i_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_valid_i  (req_valid_i),
   .enc_op0_i    (enc_op0_i),
   .enc_op1_i    (enc_op1_i),
   .enc_crn_i    (enc_crn_i),
   .enc_crm_i    (enc_crm_i),
   .enc_op2_i    (enc_op2_i),
   .cur_el_i     (cur_el_i),
   .has_el3_i    (has_el3_i),
   .l3_ctr_en_i  (l3_ctr_en_i),
   .l3_trap_i    (l3_trap_i),
   .undef_prio_i (undef_prio_i),
   .rsp_valid_o  (rsp_valid_o),
   .rsp_result_o (rsp_result_o),
   .rsp_ec_o     (rsp_ec_o)
);

// File: tb/test_ctr_acc_trap_arb.sv
`timescale 1ns/1ps
module test_ctr_acc_trap_arb;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n;
   logic req_valid, req_write;
   logic [1:0] op0; logic [2:0] op1; logic [3:0] crn, crm; logic [2:0] op2;
   logic [1:0] el;
   logic has_el2, has_el3, el2_en, l3_ctr_en, l3_trap, l2_trap;
   logic fgt, l3_fgt_en, rd_allow, wr_allow, undef_prio, undef_sel;
   logic rsp_valid; logic [1:0] rsp_result; logic [5:0] rsp_ec;

   int nchk = 0;
   int nerr = 0;
   bit finished = 0;

   ctr_acc_trap_arb i_ctr_acc_trap_arb (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
      .enc_op0_i(op0), .enc_op1_i(op1), .enc_crn_i(crn), .enc_crm_i(crm), .enc_op2_i(op2),
      .cur_el_i(el), .has_el2_i(has_el2), .has_el3_i(has_el3), .el2_enabled_i(el2_en),
      .l3_ctr_en_i(l3_ctr_en), .l3_trap_i(l3_trap), .l2_trap_i(l2_trap),
      .fgt_present_i(fgt), .l3_fgt_en_i(l3_fgt_en), .l2_rd_allow_i(rd_allow),
      .l2_wr_allow_i(wr_allow), .undef_prio_i(undef_prio), .undef_sel_i(undef_sel),
      .rsp_valid_o(rsp_valid), .rsp_result_o(rsp_result), .rsp_ec_o(rsp_ec));

   typedef struct {
      bit       vld;
      bit [1:0] res;
      bit [5:0] ec;
      string    tag;
   } exp_t;
   exp_t expq[$];

   // Behavioural reference: the requirement text turned into a decision list.
   function automatic exp_t predict();
      exp_t e;
      bit allow;
      e.tag = "R2";
      e.vld = req_valid && op0 == 2'b11 && op1 == 3'b000 && crn == 4'b1001 &&
              crm == 4'b1110 && op2 == 3'b100;
      e.res = 2'd0;
      if (!e.vld) begin
         e.tag = "R1"; e.ec = 0; return e;
      end
      allow = req_write ? wr_allow : rd_allow;
      if (el == 0) begin e.res = 2'd1; e.tag = "R3"; end
      else if (el == 3) begin e.res = 2'd0; e.tag = "R9"; end
      else if (has_el3 && undef_prio && (!l3_ctr_en || l3_trap)) begin e.res = 2'd1; e.tag = "R4"; end
      else if (el == 1 && has_el2 && el2_en && fgt && ((has_el3 && !l3_fgt_en) || !allow)) begin
         e.res = 2'd2; e.tag = "R5"; end
      else if (el == 1 && has_el2 && el2_en && l2_trap) begin e.res = 2'd2; e.tag = "R6"; end
      else if (has_el3 && (!l3_ctr_en || l3_trap)) begin
         e.res = undef_sel ? 2'd1 : 2'd3; e.tag = "R7"; end
      else begin e.res = 2'd0; e.tag = (el == 2) ? "R8" : "R2"; end
      e.ec = (e.res >= 2) ? 6'h18 : 6'h00;
      return e;
   endfunction

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic permissive();
      req_valid = 1; req_write = 0;
      op0 = 2'b11; op1 = 3'b000; crn = 4'b1001; crm = 4'b1110; op2 = 3'b100;
      el = 2'd1; has_el2 = 1; has_el3 = 1; el2_en = 1;
      l3_ctr_en = 1; l3_trap = 0; l2_trap = 0; fgt = 1; l3_fgt_en = 1;
      rd_allow = 1; wr_allow = 1; undef_prio = 0; undef_sel = 0;
   endtask

   // Called at a falling edge with inputs set: predict, wait one cycle, compare.
   task automatic tick();
      exp_t e;
      expq.push_back(predict());
      @(negedge clk);
      e = expq.pop_front();
      check(rsp_valid == e.vld, e.vld ? "R2" : "R1", "valid", rsp_valid, e.vld);
      check(rsp_result == e.res, e.tag, "result", rsp_result, e.res);
      check(rsp_ec == e.ec, "R10", "ec", rsp_ec, e.ec);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      #(8ns * 200000);
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      permissive();
      l3_trap = 1; l2_trap = 1; // would produce a trap if reset were ignored
      rst_n = 0;
      repeat (3) @(negedge clk);
      // R11: outputs held at zero during reset
      check(rsp_valid == 0, "R11", "valid in reset", rsp_valid, 0);
      check(rsp_result == 0, "R11", "result in reset", rsp_result, 0);
      check(rsp_ec == 0, "R11", "ec in reset", rsp_ec, 0);
      rst_n = 1;

      // R1: wrong op2 and wrong CRm are ignored; no request also gives nothing
      permissive(); el = 2'd3; op2 = 3'b101; tick();
      permissive(); crm = 4'b1111; tick();
      permissive(); req_valid = 0; tick();
      // R2: plain permit at level 1
      permissive(); tick();
      // R3: level 0 is undefined even when permissive
      permissive(); el = 2'd0; tick();
      // R4: early undefined beats a fine-grained trap
      permissive(); undef_prio = 1; l3_ctr_en = 0; rd_allow = 0; tick();
      permissive(); el = 2'd2; undef_prio = 1; l3_trap = 1; tick();
      // R5: direction selects the allow bit
      permissive(); rd_allow = 0; tick();
      permissive(); rd_allow = 0; req_write = 1; tick();
      permissive(); wr_allow = 0; req_write = 1; tick();
      permissive(); l3_fgt_en = 0; tick();
      // R6: level-2 trap bit, and its absence when level 2 is disabled
      permissive(); l2_trap = 1; tick();
      permissive(); l2_trap = 1; el2_en = 0; tick();
      // R7: level-3 route and the undefined substitute
      permissive(); l3_ctr_en = 0; tick();
      permissive(); l3_ctr_en = 0; undef_sel = 1; tick();
      permissive(); l3_trap = 1; tick();
      // R8: level 2 ignores level-2 checks but still sees level 3
      permissive(); el = 2'd2; l2_trap = 1; rd_allow = 0; l3_fgt_en = 0; tick();
      permissive(); el = 2'd2; l2_trap = 1; l3_trap = 1; tick();
      // R9: level 3 is permitted with every control hostile
      permissive(); el = 2'd3; l3_ctr_en = 0; l3_trap = 1; l2_trap = 1; undef_prio = 1;
      rd_allow = 0; tick();

      // Random sweep (presence flags forced to keep assumptions)
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         permissive();
         req_valid = r[0] | r[1]; req_write = r[2]; el = r[4:3];
         has_el2 = r[5]; has_el3 = r[6]; el2_en = r[7]; l3_ctr_en = r[8] | r[9];
         l3_trap = r[10] & r[11]; l2_trap = r[12] & r[13]; fgt = r[14];
         l3_fgt_en = r[15] | r[16]; rd_allow = r[17] | r[18]; wr_allow = r[19] | r[20];
         undef_prio = r[21]; undef_sel = r[22];
         if (r[23] & r[24] & r[25]) op1 = r[28:26];
         if (el2_en || el == 2'd2) has_el2 = 1;
         tick();
      end
      finish_run();
   end
endmodule